// File: doc/BRIEF.md
# Page-Mode DRAM Cache-Line Fill Controller

This block serves cache-line fills from an asynchronous DRAM that has a multiplexed address bus. A fill request carries a block address. The controller opens the addressed row once with an active-low row strobe. It then walks four consecutive column addresses with an active-low column strobe while the row stays open. Each fetched word is returned with a one-cycle valid pulse and its beat index, and the last word also carries a done flag. Once the burst ends, the row strobe stays high for a programmable recovery time. During that time the request port reports not-ready.

Two beat timings are available, chosen per request. The first is plain page mode, where a word is taken while the column strobe is still low. This gives 5-3-3-3 cycles per block with default parameters. The second is extended-data-out mode. In that mode the DRAM keeps the previous word on its pins after the column strobe rises, so the controller takes that word while it is already presenting the next column. The beat period shrinks to 5-2-2-2. The controller only reads, so it never drives the shared data pins: its pin-direction output stays in the receive state, and the write enable stays inactive.

Top module: `pgdram_fill_ctrl`

## Requirements
- R1: While reset is held, and right after it, the outputs are in their idle state. The row strobe, column strobe, output enable and write enable are all high, the data-direction output is 0, rd_valid and rd_done are 0, and req_ready is 1.
- R2: A request is accepted in a cycle where req_valid and req_ready are both 1. Call that cycle k=0. In cycle k=1 the row strobe falls, and dram_addr then carries req_addr[17:8]. The row strobe falls exactly once per burst and stays low until the last word is taken.
- R3: Each burst has exactly four column-strobe falls. At each fall dram_addr is {req_addr[7:0], b}, where b counts 0, 1, 2, 3 in that order. The address stays stable while the column strobe is low.
- R4: With edo_mode=0 at acceptance (page mode), the words are taken in cycles k=5, 8, 11 and 14. rd_valid is therefore high in cycles k=6, 9, 12 and 15.
- R5: With edo_mode=1 at acceptance (extended-data-out mode), the words are taken in cycles k=5, 7, 9 and 11. Each of these cycles falls after the column strobe has risen. rd_valid is high in cycles k=6, 8, 10 and 12.
- R6: For each beat, rd_data equals the DRAM word at (row, column) for that beat. rd_beat gives the beat number 0 to 3, and rd_done is 1 only together with beat 3.
- R7: The output enable is low from the first column-strobe cycle (k=4) through the cycle in which the last word is taken. The write enable stays high and the data-direction output stays 0 at all times.
- R8: After the last word, the row strobe rises and stays high for PRE_CYC (3) cycles. req_ready is 0 from acceptance through that recovery time, so in page mode it returns at k=18 and in extended-data-out mode at k=15.
- R9: The mode is sampled only at acceptance. Changes on edo_mode or req_addr during a burst do not alter that burst's timing, columns or data.
- R10: A request held on req_valid during a burst or during recovery is accepted in the first cycle req_ready returns. That is 18 cycles after a page-mode burst was accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Fill request present |
| req_addr | input | 18 | Block address: row in the upper 10 bits, column block in the lower 8 |
| edo_mode | input | 1 | 1 selects extended-data-out timing, 0 selects page mode |
| req_ready | output | 1 | Controller can accept a request this cycle |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_oe_n | output | 1 | DRAM output enable, active low |
| dram_we_n | output | 1 | DRAM write enable, active low, held high |
| dram_dq_oe | output | 1 | Data pin drive enable, held 0 (receive) |
| dram_dq_in | input | 64 | Data from the DRAM pins |
| rd_valid | output | 1 | A fetched word is on rd_data |
| rd_data | output | 64 | Fetched word |
| rd_beat | output | 2 | Beat number of rd_data |
| rd_done | output | 1 | Last word of the block |

## Verification
The DRAM model in the bench drives valid data only while the column strobe is low in page mode. A controller that took page-mode words one cycle late, as extended-data-out timing would, therefore returns garbage words. In extended-data-out mode, the model keeps the previous column's word on the pins after the strobe rises and replaces it when the next column strobe falls. A controller that kept page timing for this mode would show the wrong beat spacing, and one that sampled during the new strobe would return the following column's word. Address vectors with all-ones and alternating bit patterns expose a swapped row/column split or a column that does not step upward. A request held during recovery, and mode and address inputs changed during a burst, expose a shortened precharge and inputs that are sampled too late.

// File: rtl/pgdram_pkg.sv
package pgdram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ROW,
      ST_CSET,
      ST_CSTB,
      ST_TAIL,
      ST_PRE
   } pg_state_t;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pgdram_addr.sv
module pgdram_addr #(
   parameter int ROW_W  = 10,
   parameter int COL_W  = 10,
   parameter int BEAT_W = 2,
   localparam int AW    = (ROW_W > COL_W) ? ROW_W : COL_W,
   localparam int BLK_W = ROW_W + COL_W - BEAT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [BLK_W-1:0] blk_addr,
   input  logic             sel_row,
   input  logic [BEAT_W-1:0] beat,
   output logic [AW-1:0]    dram_addr
);

   localparam int CHI_W = COL_W - BEAT_W;

   if (COL_W <= BEAT_W) begin : g_bad_col
      $error("column width must exceed the beat index width");
   end
   if (ROW_W < 1) begin : g_bad_row
      $error("row width must be at least 1");
   end

   logic [ROW_W-1:0] row_q;
   logic [CHI_W-1:0] chi_q;
   logic [COL_W-1:0] col_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q <= '0;
         chi_q <= '0;
      end else if (load) begin
         row_q <= blk_addr[BLK_W-1 -: ROW_W];
         chi_q <= blk_addr[CHI_W-1:0];
      end
   end

   assign col_w = {chi_q, beat};

   if (ROW_W == COL_W) begin : g_same
      assign dram_addr = sel_row ? row_q : col_w;
   end else begin : g_pad
      assign dram_addr = sel_row ? AW'(row_q) : AW'(col_w);
   end

endmodule

// File: rtl/pgdram_seq.sv
module pgdram_seq
   import pgdram_pkg::*;
#(
   parameter int BURST       = 4,
   parameter int ROW_CYC     = 2,
   parameter int PG_CAS_LO   = 2,
   parameter int EDO_CAS_LO  = 1,
   parameter int PRE_CYC     = 3,
   parameter bit SUPPORT_EDO = 1'b1,
   localparam int BEAT_W     = (BURST > 1) ? $clog2(BURST) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              edo_mode,
   output logic              req_ready,
   output logic              accept,
   output logic              sel_row,
   output logic [BEAT_W-1:0] beat,
   output logic              ras_n,
   output logic              cas_n,
   output logic              oe_n,
   output logic              cap_stb,
   output logic [BEAT_W-1:0] cap_beat,
   output logic              cap_last
);

   localparam int MAXC  = imax(imax(ROW_CYC, PRE_CYC), imax(PG_CAS_LO, EDO_CAS_LO));
   localparam int CNT_W = $clog2(MAXC + 1);
   localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST - 1);
   localparam logic [CNT_W-1:0]  ROW_LD    = CNT_W'(ROW_CYC - 1);
   localparam logic [CNT_W-1:0]  PG_LD     = CNT_W'(PG_CAS_LO - 1);
   localparam logic [CNT_W-1:0]  EDO_LD    = CNT_W'(EDO_CAS_LO - 1);
   localparam logic [CNT_W-1:0]  PRE_LD    = CNT_W'(PRE_CYC - 1);
   localparam logic [CNT_W:0]    PRE_MIN   = (CNT_W+1)'(PRE_CYC);

   if (BURST < 2 || (1 << BEAT_W) != BURST) begin : g_bad_burst
      $error("burst length must be a power of two, at least 2");
   end
   if (ROW_CYC < 1 || PG_CAS_LO < 1 || EDO_CAS_LO < 1 || PRE_CYC < 1) begin : g_bad_time
      $error("every timing parameter must be at least one cycle");
   end

   pg_state_t         st;
   logic [CNT_W-1:0]  cnt;
   logic [BEAT_W-1:0] bt;
   logic              edo_q;
   logic              mode_req;
   logic              cnt_zero;

   if (SUPPORT_EDO) begin : g_edo
      assign mode_req = edo_mode;
   end else begin : g_page_only
      assign mode_req = 1'b0;
   end

   assign req_ready = (st == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign cnt_zero  = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         cnt   <= '0;
         bt    <= '0;
         edo_q <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (accept) begin
                  st    <= ST_ROW;
                  cnt   <= ROW_LD;
                  bt    <= '0;
                  edo_q <= mode_req;
               end
            end
            ST_ROW: begin
               if (cnt_zero) st <= ST_CSET;
               else          cnt <= cnt - 1'b1;
            end
            ST_CSET: begin
               st  <= ST_CSTB;
               cnt <= edo_q ? EDO_LD : PG_LD;
            end
            ST_CSTB: begin
               if (!cnt_zero) begin
                  cnt <= cnt - 1'b1;
               end else if (bt == LAST_BEAT) begin
                  if (edo_q) begin
                     st <= ST_TAIL;
                  end else begin
                     st  <= ST_PRE;
                     cnt <= PRE_LD;
                  end
               end else begin
                  bt <= bt + 1'b1;
                  st <= ST_CSET;
               end
            end
            ST_TAIL: begin
               st  <= ST_PRE;
               cnt <= PRE_LD;
            end
            ST_PRE: begin
               if (cnt_zero) st <= ST_IDLE;
               else          cnt <= cnt - 1'b1;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // page mode takes the word in the last strobe-low cycle; the other mode
   // takes it one cycle later, while the next column is being set up
   always_comb begin
      cap_stb = 1'b0;
      if (!edo_q && st == ST_CSTB && cnt_zero) cap_stb = 1'b1;
      if (edo_q && st == ST_CSET && bt != '0)  cap_stb = 1'b1;
      if (st == ST_TAIL)                       cap_stb = 1'b1;
   end

   assign cap_beat = (edo_q && st == ST_CSET) ? bt - 1'b1 : bt;
   assign cap_last = (cap_beat == LAST_BEAT);
   assign beat     = bt;
   assign sel_row  = !(st inside {ST_CSET, ST_CSTB, ST_TAIL});
   assign ras_n    = !(st inside {ST_ROW, ST_CSET, ST_CSTB, ST_TAIL});
   assign cas_n    = !(st == ST_CSTB);
   assign oe_n     = !(st == ST_CSTB || st == ST_TAIL || (st == ST_CSET && bt != '0));

   // run length of row strobe high time, used to check the recovery window
   logic [CNT_W:0] hi_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          hi_run <= PRE_MIN;
      else if (!ras_n)     hi_run <= '0;
      else if (hi_run < PRE_MIN) hi_run <= hi_run + 1'b1;
   end

   p_pre_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> hi_run >= PRE_MIN);

   p_beat_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CSET && $past(st) == ST_CSTB) |-> bt == $past(bt) + 1'b1);

   p_ready_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (ras_n && cas_n && oe_n));

endmodule

// File: rtl/pgdram_cap.sv
module pgdram_cap #(
   parameter int DW     = 64,
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_stb,
   input  logic [BEAT_W-1:0] cap_beat,
   input  logic              cap_last,
   input  logic [DW-1:0]     dq_in,
   output logic              rd_valid,
   output logic [DW-1:0]     rd_data,
   output logic [BEAT_W-1:0] rd_beat,
   output logic              rd_done
);

   if (DW < 1) begin : g_bad_dw
      $error("data width must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
         rd_beat  <= '0;
         rd_done  <= 1'b0;
      end else begin
         rd_valid <= cap_stb;
         rd_done  <= cap_stb && cap_last;
         if (cap_stb) begin
            rd_data <= dq_in;
            rd_beat <= cap_beat;
         end
      end
   end

   // expected next beat number, for ordering check
   logic [BEAT_W-1:0] nxt_beat;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                nxt_beat <= '0;
      else if (rd_valid && rd_done) nxt_beat <= '0;
      else if (rd_valid)         nxt_beat <= rd_beat + 1'b1;
   end

   p_beat_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> rd_beat == nxt_beat);

   p_done_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |-> rd_valid);

endmodule

// File: rtl/pgdram_fill_ctrl.sv
module pgdram_fill_ctrl #(
   parameter int DW          = 64,
   parameter int ROW_W       = 10,
   parameter int COL_W       = 10,
   parameter int BURST       = 4,
   parameter int ROW_CYC     = 2,
   parameter int PG_CAS_LO   = 2,
   parameter int EDO_CAS_LO  = 1,
   parameter int PRE_CYC     = 3,
   parameter bit SUPPORT_EDO = 1'b1
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic                                      req_valid,
   input  logic [ROW_W+COL_W-$clog2(BURST)-1:0]      req_addr,
   input  logic                                      edo_mode,
   output logic                                      req_ready,
   output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
   output logic                                      dram_ras_n,
   output logic                                      dram_cas_n,
   output logic                                      dram_oe_n,
   output logic                                      dram_we_n,
   output logic                                      dram_dq_oe,
   input  logic [DW-1:0]                             dram_dq_in,
   output logic                                      rd_valid,
   output logic [DW-1:0]                             rd_data,
   output logic [$clog2(BURST)-1:0]                  rd_beat,
   output logic                                      rd_done
);

   localparam int BEAT_W = $clog2(BURST);

   logic              accept;
   logic              sel_row;
   logic [BEAT_W-1:0] beat;
   logic              cap_stb;
   logic [BEAT_W-1:0] cap_beat;
   logic              cap_last;

   pgdram_seq #(
      .BURST       (BURST),
      .ROW_CYC     (ROW_CYC),
      .PG_CAS_LO   (PG_CAS_LO),
      .EDO_CAS_LO  (EDO_CAS_LO),
      .PRE_CYC     (PRE_CYC),
      .SUPPORT_EDO (SUPPORT_EDO)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .edo_mode  (edo_mode),
      .req_ready (req_ready),
      .accept    (accept),
      .sel_row   (sel_row),
      .beat      (beat),
      .ras_n     (dram_ras_n),
      .cas_n     (dram_cas_n),
      .oe_n      (dram_oe_n),
      .cap_stb   (cap_stb),
      .cap_beat  (cap_beat),
      .cap_last  (cap_last)
   );

   pgdram_addr #(
      .ROW_W  (ROW_W),
      .COL_W  (COL_W),
      .BEAT_W (BEAT_W)
   ) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .blk_addr  (req_addr),
      .sel_row   (sel_row),
      .beat      (beat),
      .dram_addr (dram_addr)
   );

   pgdram_cap #(
      .DW     (DW),
      .BEAT_W (BEAT_W)
   ) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_stb  (cap_stb),
      .cap_beat (cap_beat),
      .cap_last (cap_last),
      .dq_in    (dram_dq_in),
      .rd_valid (rd_valid),
      .rd_data  (rd_data),
      .rd_beat  (rd_beat),
      .rd_done  (rd_done)
   );

   // read-only controller: pins stay in receive direction, no write strobe
   assign dram_we_n  = 1'b1;
   assign dram_dq_oe = 1'b0;

   p_cas_in_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_cas_n |-> !dram_ras_n);

   p_oe_in_row_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_oe_n |-> !dram_ras_n);

   p_col_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!dram_cas_n && $past(!dram_cas_n)) |-> $stable(dram_addr));

   p_valid_after_row_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !$past(req_ready));

endmodule

// File: tb/sim_pgdram_fill_ctrl.sv
module sim_pgdram_fill_ctrl;

   localparam int DW      = 64;
   localparam int BLK_W   = 18;
   localparam int ROW_CYC = 2;
   localparam int PLO     = 2;
   localparam int ELO     = 1;
   localparam int PRE     = 3;
   localparam logic [DW-1:0] GARB = 64'hBAD0_BAD0_BAD0_BAD0;

   // {edo_mode, block address}
   localparam int NVEC = 6;
   localparam logic [BLK_W:0] VEC [NVEC] = '{
      {1'b0, 18'h00000},
      {1'b1, 18'h3FFFF},
      {1'b0, 18'h2A5A5},
      {1'b1, 18'h15A5A},
      {1'b0, 18'h00FFF},
      {1'b1, 18'h3F000}
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic [BLK_W-1:0] req_addr = '0;
   logic            edo_mode = 1'b0;
   logic            req_ready;
   logic [9:0]      dram_addr;
   logic            dram_ras_n, dram_cas_n, dram_oe_n, dram_we_n, dram_dq_oe;
   logic [DW-1:0]   dq;
   logic            rd_valid;
   logic [DW-1:0]   rd_data;
   logic [1:0]      rd_beat;
   logic            rd_done;

   pgdram_fill_ctrl u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_addr   (req_addr),
      .edo_mode   (edo_mode),
      .req_ready  (req_ready),
      .dram_addr  (dram_addr),
      .dram_ras_n (dram_ras_n),
      .dram_cas_n (dram_cas_n),
      .dram_oe_n  (dram_oe_n),
      .dram_we_n  (dram_we_n),
      .dram_dq_oe (dram_dq_oe),
      .dram_dq_in (dq),
      .rd_valid   (rd_valid),
      .rd_data    (rd_data),
      .rd_beat    (rd_beat),
      .rd_done    (rd_done)
   );

   always #2 clk = ~clk;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [DW-1:0] word(input logic [9:0] r, input logic [9:0] c);
      logic [15:0] mix;
      mix = 16'(r) * 16'd7 + 16'(c) * 16'd13;
      return {r ^ 10'h2B7, 6'h2D, c, 6'h1E, mix, 16'hF00D};
   endfunction

   // DRAM model
   logic       cur_edo = 1'b0;
   logic       ras_q = 1'b1;
   logic [9:0] m_row = '0;
   logic [9:0] m_held = '0;
   always @(posedge clk) begin
      ras_q <= dram_ras_n;
      if (!dram_ras_n && ras_q) m_row <= dram_addr;
      if (!dram_cas_n) m_held <= dram_addr;
   end
   always_comb begin
      if (dram_oe_n)        dq = GARB;
      else if (!dram_cas_n) dq = word(m_row, dram_addr);
      else if (cur_edo)     dq = word(m_row, m_held);
      else                  dq = GARB;
   end

   // monitor, samples at the falling edge
   int acc = 0, prev_acc = 0;
   int nras = 0, ras_fall_k = -1, ras_rise_k = -1;
   logic [9:0] row_seen = '0;
   logic [9:0] col_seen [4];
   int ncol = 0, nv = 0;
   int vt [4];
   logic [DW-1:0] vd [4];
   logic [1:0] vb [4];
   logic vdone [4];
   int oe_first = -1, oe_last = -1, ready_k = -1;
   logic we_bad = 1'b0;
   logic ras_m = 1'b1, cas_m = 1'b1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (req_valid && req_ready) begin
            prev_acc = acc; acc = cyc; cur_edo = edo_mode;
            nras = 0; ras_fall_k = -1; ras_rise_k = -1; ncol = 0; nv = 0;
            oe_first = -1; oe_last = -1; ready_k = -1; we_bad = 1'b0;
         end else begin
            int k;
            k = cyc - acc;
            if (!dram_ras_n && ras_m) begin nras++; row_seen = dram_addr; ras_fall_k = k; end
            if (dram_ras_n && !ras_m && ras_rise_k < 0) ras_rise_k = k;
            if (!dram_cas_n && cas_m) begin
               if (ncol < 4) col_seen[ncol] = dram_addr;
               ncol++;
            end
            if (rd_valid) begin
               if (nv < 4) begin vt[nv] = k; vd[nv] = rd_data; vb[nv] = rd_beat; vdone[nv] = rd_done; end
               nv++;
            end
            if (!dram_oe_n) begin
               if (oe_first < 0) oe_first = k;
               oe_last = k;
            end
            if (req_ready && ready_k < 0) ready_k = k;
         end
         if (!dram_we_n || dram_dq_oe) we_bad = 1'b1;
         ras_m = dram_ras_n; cas_m = dram_cas_n;
      end
   end

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   function automatic int cap_k(input logic m, input int i);
      return m ? (ROW_CYC + 2 + ELO + i * (1 + ELO)) : (ROW_CYC + 1 + PLO + i * (1 + PLO));
   endfunction

   task automatic wait_ready();
      while (!req_ready) begin @(posedge clk); #1; end
   endtask

   task automatic do_burst(input logic [BLK_W-1:0] a, input logic m, input bit flip);
      @(posedge clk); #1;
      req_valid = 1'b1; req_addr = a; edo_mode = m;
      wait_ready();
      @(posedge clk); #1;
      req_valid = 1'b0;
      if (flip) begin edo_mode = !m; req_addr = ~a; end
      wait_ready();
      @(posedge clk); #1;
   endtask

   task automatic check_burst(input logic [BLK_W-1:0] a, input logic m);
      logic [9:0] row;
      int lastc;
      string rt;
      row = a[17:8];
      lastc = cap_k(m, 3);
      rt = m ? "R5" : "R4";
      chk(nras == 1 && ras_fall_k == 1 && row_seen == row, "R2", "row strobe/address",
          {32'(nras), 22'(ras_fall_k), row_seen}, {32'd1, 22'd1, row});
      chk(ncol == 4, "R3", "column strobe count", 64'(ncol), 64'd4);
      for (int i = 0; i < 4; i++) begin
         chk(col_seen[i] == {a[7:0], 2'(i)}, "R3", "column address",
             64'(col_seen[i]), 64'({a[7:0], 2'(i)}));
      end
      chk(nv == 4, "R6", "beat count", 64'(nv), 64'd4);
      for (int i = 0; i < 4; i++) begin
         chk(vt[i] == cap_k(m, i) + 1, rt, "beat cycle", 64'(vt[i]), 64'(cap_k(m, i) + 1));
         chk(vd[i] == word(row, {a[7:0], 2'(i)}), "R6", "beat data",
             vd[i], word(row, {a[7:0], 2'(i)}));
         chk(vb[i] == 2'(i) && vdone[i] == (i == 3), "R6", "beat index/done",
             {vb[i], 7'b0, vdone[i]}, {2'(i), 7'b0, 1'(i == 3)});
      end
      chk(oe_first == ROW_CYC + 2 && oe_last == lastc, "R7", "output enable window",
          {32'(oe_first), 32'(oe_last)}, {32'(ROW_CYC + 2), 32'(lastc)});
      chk(!we_bad, "R7", "write enable/drive held off", 64'(we_bad), 64'd0);
      chk(ras_rise_k == lastc + 1 && ready_k == lastc + 1 + PRE, "R8", "recovery/ready",
          {32'(ras_rise_k), 32'(ready_k)}, {32'(lastc + 1), 32'(lastc + 1 + PRE)});
   endtask

   initial begin
      #400000;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(dram_ras_n && dram_cas_n && dram_oe_n && dram_we_n && !dram_dq_oe, "R1",
          "strobes in reset", {59'b0, dram_ras_n, dram_cas_n, dram_oe_n, dram_we_n, dram_dq_oe},
          64'b11110);
      chk(!rd_valid && !rd_done && req_ready, "R1", "valid/ready in reset",
          {61'b0, rd_valid, rd_done, req_ready}, 64'b001);
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      chk(dram_ras_n && dram_cas_n && req_ready && !rd_valid, "R1", "after reset",
          {60'b0, dram_ras_n, dram_cas_n, req_ready, rd_valid}, 64'b1110);

      // vector table walk: R2..R8 in both modes
      for (int v = 0; v < NVEC; v++) begin
         do_burst(VEC[v][BLK_W-1:0], VEC[v][BLK_W], 1'b0);
         check_burst(VEC[v][BLK_W-1:0], VEC[v][BLK_W]);
      end

      // R9: mode and address flipped during the burst
      do_burst(18'h1C3C3, 1'b0, 1'b1);
      check_burst(18'h1C3C3, 1'b0);
      do_burst(18'h0B00B, 1'b1, 1'b1);
      check_burst(18'h0B00B, 1'b1);

      // R10: second request held during a page burst and its recovery
      @(posedge clk); #1;
      req_valid = 1'b1; req_addr = 18'h23456; edo_mode = 1'b0;
      wait_ready();
      @(posedge clk); #1;
      req_addr = 18'h3ABCD; edo_mode = 1'b1;
      @(posedge clk); #1;
      wait_ready();
      @(posedge clk); #1;
      req_valid = 1'b0;
      chk(acc - prev_acc == cap_k(1'b0, 3) + 1 + PRE, "R10", "held request accept gap",
          64'(acc - prev_acc), 64'(cap_k(1'b0, 3) + 1 + PRE));
      wait_ready();
      @(posedge clk); #1;
      check_burst(18'h3ABCD, 1'b1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule